// File: doc/BRIEF.md
# Keyed Windowed Independent Watchdog

This block is a watchdog timer that advances on strobes from a slow, free-running clock source. Software reaches it through one write port: a select field picks the key, prescaler, reload or window register, and the data field carries the value. Magic key values start the timer, refresh it and open the configuration registers for writing. Once started, the timer cannot be stopped by any write. Only a reset returns it to idle. A strap input can start it with no software involved.

A 12-bit down-counter steps once per prescaler period. The period is a power-of-two count of slow strobes. When the counter is already at zero and another step falls due, the block raises a one-cycle reset request and reloads the counter. A window value limits when a refresh is accepted: a refresh that arrives while the counter is still above the window also raises the reset request. New configuration values are first held in staging registers. They take effect on the next slow strobe, and a busy bit for each register shows the update is still pending.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the counter reads 0xFFF, no busy bit is set, the block is locked, and the effective settings are prescaler code 0, reload 0xFFF and window 0xFFF. `running` equals the value of `hw_start` sampled during reset.
- R2: A key write (select 0) of 0xCCCC sets `running`. No later write of any key or value clears it; only reset does.
- R3: The counter changes only while `running` is high, or through a refresh or a window update. While running, it decrements by one for each completed prescaler period of `slow_tick` strobes.
- R4: The prescaler code (3 bits) selects a period of 4 << code strobes for codes 0 to 6, and 256 strobes for code 7.
- R5: A key write of 0xAAAA loads the counter from the effective reload value and restarts the prescaler period.
- R6: A key write of 0x5555 unlocks the block. A key write of any other value locks it. Prescaler writes (select 1) and reload writes (select 2) are ignored while locked. Window writes (select 3) are accepted at any time.
- R7: A counting step that falls due while the counter is 0 raises `wdg_reset` for exactly one clock and reloads the counter. `wdg_reset` is only ever raised while running.
- R8: An accepted write sets its busy bit: bit 0 for the prescaler, bit 1 for reload, bit 2 for window. The bit clears on the next `slow_tick` strobe, and the new value takes effect at that same strobe.
- R9: While running, a refresh key arriving when the counter is strictly above the effective window raises `wdg_reset` for one clock. A refresh at or below the window does not.
- R10: When a new window value takes effect, the counter is also loaded from the effective reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_start | input | 1 | Strap; when high during reset, the timer starts running |
| slow_tick | input | 1 | One-cycle strobe from the slow clock source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| running | output | 1 | Timer started |
| unlocked | output | 1 | Prescaler and reload writes allowed |
| busy | output | 3 | Pending updates: bit 0 prescaler, bit 1 reload, bit 2 window |
| count | output | 12 | Current counter value |
| wdg_reset | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the early-refresh rule with a counter value equal to the window. Getting there needs an accepted unlock, a staged reload, a staged window that itself reloads the counter, and then an exact number of strobes. The stimulus first applies a reload of 0x010 and a window of 0x008 and refreshes once to see the early reset. It then issues exactly 32 strobes at the divide-by-4 setting, which lands the counter on 0x008, and refreshes there, where no reset may appear.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes 16-bit key writes and a 2-bit register select.
package wdg_pkg;
    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_FEED   = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN   = 16'h5555;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_PRESC  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_WINDOW = 2'd3
    } wdg_sel_e;
endpackage

// File: rtl/wdg_key_ctl.sv
// Key decoder: holds the run latch and the write-unlock flag.
// Assumes key_wr is a single-cycle strobe; the run latch is cleared only by reset.
module wdg_key_ctl
    import wdg_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_start,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    output logic             running,
    output logic             unlocked,
    output logic             cmd_feed
);
    assign cmd_feed = key_wr && (key_data == KEY_FEED);

    // Run latch: strap sampled in reset, start key sets it, nothing clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= hw_start;
        else if (key_wr && key_data == KEY_START)
            running <= 1'b1;
    end

    // Unlock flag: open key sets it, every other key value clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (key_wr)
            unlocked <= (key_data == KEY_OPEN);
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R2
    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != KEY_OPEN) |=> !unlocked); // R6
endmodule

// File: rtl/wdg_cfg_sync.sv
// Staging register with a busy flag: a write is held until the next slow
// strobe, where it moves to the effective copy. Assumes slow_tick is a strobe.
module wdg_cfg_sync #(
    parameter int             W       = 12,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         slow_tick,
    output logic [W-1:0] value,
    output logic         busy,
    output logic         applied
);
    logic [W-1:0] staged;

    assign applied = slow_tick && busy;

    // Staging and busy flag: a write wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= RST_VAL;
            busy   <= 1'b0;
        end else if (wr) begin
            staged <= wr_data;
            busy   <= 1'b1;
        end else if (applied) begin
            busy   <= 1'b0;
        end
    end

    // Effective copy: takes the staged value on the strobe that ends busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (applied)
            value <= staged;
    end

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slow_tick && !wr) |=> !busy); // R8
    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(value)); // R8
endmodule

// File: rtl/wdg_prescaler.sv
// Power-of-two divider of slow strobes. It emits one step per period while
// running. Assumes PRE_W bits cover the largest period (256).
module wdg_prescaler #(
    parameter int CODE_W = 3,
    parameter int PRE_W  = 8,
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slow_tick,
    input  logic              clear,
    input  logic [CODE_W-1:0] code,
    output logic              step
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE - 1);

    logic [CODE_W-1:0] eff_code;
    logic [PRE_W:0]    period;
    logic [PRE_W-1:0]  limit;
    logic [PRE_W-1:0]  phase;

    // Period decode: the top code repeats the largest power.
    always_comb begin
        eff_code = (code == CODE_W'(MAX_CODE)) ? TOP_CODE : code;
        period   = (PRE_W+1)'(1 << BASE_SHIFT) << eff_code;
        limit    = PRE_W'(period - 1'b1);
    end

    assign step = run && slow_tick && (phase >= limit);

    // Phase counter: counts strobes, wraps on a step, restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            phase <= '0;
        else if (step)
            phase <= '0;
        else if (run && slow_tick)
            phase <= phase + 1'b1;
    end

    AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step); // R4
endmodule

// File: rtl/wdg_core.sv
// Down-counter with window compare and reset-request generation.
// Assumes feed, win_load and step are single-cycle; feed has priority.
module wdg_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             step,
    input  logic             feed,
    input  logic             win_load,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] win_val,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_INIT = '1;

    // Counter and reset request: feed, then window reload, then counting step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_INIT;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (feed) begin
                if (running && count > win_val)
                    fire <= 1'b1;
                count <= reload_val;
            end else if (win_load) begin
                count <= reload_val;
            end else if (step) begin
                if (count == '0) begin
                    fire  <= 1'b1;
                    count <= reload_val;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

    AST_FIRE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> running); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !feed && !win_load) |=> $stable(count)); // R3
    AST_LOW_FEED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && count <= win_val) |=> !fire); // R9
endmodule

// File: rtl/wdg_keyed_top.sv
// Keyed windowed watchdog top: write decode, key control, three staged
// configuration registers, prescaler and down-counter.
// Assumes slow_tick is a one-cycle strobe already in the clk domain.
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12,
    parameter int CODE_W = 3,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_start,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              running,
    output logic              unlocked,
    output logic [2:0]        busy,
    output logic [CNT_W-1:0]  count,
    output logic              wdg_reset
);
    logic              key_wr, presc_wr, reload_wr, win_wr;
    logic              feed, step;
    logic [CODE_W-1:0] presc_code;
    logic [CNT_W-1:0]  reload_val, win_val;
    logic              presc_ap, reload_ap, win_ap;

    // Write decode: configuration writes gated by the unlock flag, window open.
    always_comb begin
        key_wr    = wr_en && (wr_sel == SEL_KEY);
        presc_wr  = wr_en && (wr_sel == SEL_PRESC)  && unlocked;
        reload_wr = wr_en && (wr_sel == SEL_RELOAD) && unlocked;
        win_wr    = wr_en && (wr_sel == SEL_WINDOW);
    end

    wdg_key_ctl #(.KEY_W(DATA_W)) u_key (
        .clk(clk), .rst_n(rst_n), .hw_start(hw_start),
        .key_wr(key_wr), .key_data(wr_data),
        .running(running), .unlocked(unlocked), .cmd_feed(feed)
    );

    wdg_cfg_sync #(.W(CODE_W), .RST_VAL('0)) u_presc_reg (
        .clk(clk), .rst_n(rst_n), .wr(presc_wr), .wr_data(wr_data[CODE_W-1:0]),
        .slow_tick(slow_tick), .value(presc_code), .busy(busy[0]), .applied(presc_ap)
    );

    wdg_cfg_sync #(.W(CNT_W), .RST_VAL('1)) u_reload_reg (
        .clk(clk), .rst_n(rst_n), .wr(reload_wr), .wr_data(wr_data[CNT_W-1:0]),
        .slow_tick(slow_tick), .value(reload_val), .busy(busy[1]), .applied(reload_ap)
    );

    wdg_cfg_sync #(.W(CNT_W), .RST_VAL('1)) u_win_reg (
        .clk(clk), .rst_n(rst_n), .wr(win_wr), .wr_data(wr_data[CNT_W-1:0]),
        .slow_tick(slow_tick), .value(win_val), .busy(busy[2]), .applied(win_ap)
    );

    wdg_prescaler #(.CODE_W(CODE_W), .PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(running), .slow_tick(slow_tick),
        .clear(feed || win_ap), .code(presc_code), .step(step)
    );

    wdg_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .running(running), .step(step),
        .feed(feed), .win_load(win_ap), .reload_val(reload_val),
        .win_val(win_val), .count(count), .fire(wdg_reset)
    );

    AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RELOAD && !unlocked && !busy[1]) |=> !busy[1]); // R6
    AST_APPLY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_ap || reload_ap) |-> slow_tick); // R8
endmodule

// File: tb/sim_wdg_keyed_top.sv
`timescale 1ns/1ps
module sim_wdg_keyed_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_start = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        running, unlocked, wdg_reset;
    logic [2:0]  busy;
    logic [11:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wdg_keyed_top u0 (
        .clk(clk), .rst_n(rst_n), .hw_start(hw_start), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .running(running), .unlocked(unlocked), .busy(busy),
        .count(count), .wdg_reset(wdg_reset)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; hw_start = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        hw_start = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1", "count", 32'(count), 32'hFFF);
        chk("R1", "running", 32'(running), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "unlocked", 32'(unlocked), 0);
        chk("R1", "reset out", 32'(wdg_reset), 0);
    endtask

    task automatic t_idle;
        ticks(20);
        chk("R3", "idle count", 32'(count), 32'hFFF);
        chk("R3", "idle reset out", 32'(wdg_reset), 0);
    endtask

    task automatic t_lock;
        wr(2'd2, 16'h0010);
        chk("R6", "locked reload busy", 32'(busy), 0);
        wr(2'd0, 16'hAAAA);
        chk("R6", "locked reload ignored", 32'(count), 32'hFFF);
        wr(2'd0, 16'h5555);
        chk("R6", "unlock", 32'(unlocked), 1);
        wr(2'd2, 16'h0010);
        chk("R8", "reload busy bit1", 32'(busy), 32'h2);
        ticks(1);
        chk("R8", "reload busy clears", 32'(busy), 0);
        wr(2'd0, 16'hAAAA);
        chk("R5", "feed loads reload", 32'(count), 32'h010);
        chk("R6", "feed relocks", 32'(unlocked), 0);
    endtask

    task automatic t_start;
        wr(2'd0, 16'hCCCC);
        chk("R2", "start", 32'(running), 1);
        wr(2'd0, 16'h5555);
        chk("R6", "unlock again", 32'(unlocked), 1);
        wr(2'd0, 16'h1234);
        chk("R6", "other key relocks", 32'(unlocked), 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'hFFFF);
        wr(2'd3, 16'h0FFF);
        ticks(1);
        chk("R2", "no write stops", 32'(running), 1);
    endtask

    task automatic t_presc;
        wr(2'd0, 16'hAAAA);
        ticks(3);
        chk("R4", "div4 before", 32'(count), 32'h010);
        ticks(1);
        chk("R3", "div4 step", 32'(count), 32'h00F);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0001);
        chk("R8", "presc busy bit0", 32'(busy), 32'h1);
        ticks(1);
        chk("R8", "presc busy clears", 32'(busy), 0);
        wr(2'd0, 16'hAAAA);
        ticks(7);
        chk("R4", "div8 before", 32'(count), 32'h010);
        ticks(1);
        chk("R4", "div8 step", 32'(count), 32'h00F);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0007);
        ticks(1);
        wr(2'd0, 16'hAAAA);
        ticks(255);
        chk("R4", "code7 before", 32'(count), 32'h010);
        ticks(1);
        chk("R4", "code7 is 256", 32'(count), 32'h00F);
    endtask

    task automatic t_expire;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0002);
        ticks(1);
        wr(2'd0, 16'hAAAA);
        chk("R5", "feed to 2", 32'(count), 32'h002);
        ticks(11);
        chk("R7", "at zero", 32'(count), 0);
        chk("R7", "no early pulse", 32'(wdg_reset), 0);
        ticks(1);
        chk("R7", "expiry pulse", 32'(wdg_reset), 1);
        chk("R7", "reloaded", 32'(count), 32'h002);
        @(negedge clk);
        chk("R7", "pulse one clock", 32'(wdg_reset), 0);
    endtask

    task automatic t_window;
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h0010);
        ticks(1);
        wr(2'd3, 16'h0008);
        chk("R8", "window busy bit2", 32'(busy), 32'h4);
        ticks(1);
        chk("R8", "window busy clears", 32'(busy), 0);
        chk("R10", "window apply reloads", 32'(count), 32'h010);
        wr(2'd0, 16'hAAAA);
        chk("R9", "early feed pulse", 32'(wdg_reset), 1);
        chk("R9", "early feed reloads", 32'(count), 32'h010);
        ticks(32);
        chk("R9", "at window", 32'(count), 32'h008);
        wr(2'd0, 16'hAAAA);
        chk("R9", "feed at window quiet", 32'(wdg_reset), 0);
        chk("R5", "feed in window", 32'(count), 32'h010);
    endtask

    task automatic t_strap;
        do_reset(1'b0);
        chk("R2", "reset clears run", 32'(running), 0);
        do_reset(1'b1);
        chk("R1", "strap starts", 32'(running), 1);
        chk("R1", "strap count", 32'(count), 32'hFFF);
        ticks(4);
        chk("R3", "strap counts", 32'(count), 32'hFFE);
    endtask

    initial begin
        t_reset;
        t_idle;
        t_lock;
        t_start;
        t_presc;
        t_expire;
        t_window;
        t_strap;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule